// File: doc/BRIEF.md
# I2C Master Symbol Engine

This block drives an open-drain I2C bus as a master, one bus symbol at a time. A controller gives it a single command: START, STOP, write a byte, read a byte with a chosen acknowledge level, or a bus-recovery sequence. The block then produces the SCL and SDA waveforms with programmable timing. It never drives a line high. A logical 1 on either line means the line is released, and the pad or the pull-up takes it high. The controller builds whole transfers from these commands. The engine itself has no idea of addresses or transaction structure.

Timing is built from a delay unit of `div_i + 1` clock cycles, taken from a reloading down-counter. Every edge on SCL or SDA falls on a unit boundary. When a write finishes, the engine returns the raw acknowledge level it sampled from the bus. When a read finishes, it returns the received byte. A NACK does not stop the engine. It only reports the level, and the controller decides what to do next. The recovery command is for a slave that is stuck mid-byte. It releases SDA, clocks SCL nine times and closes with a STOP.

Top module: `i2c_sym_engine`

## Requirements
- R1: While reset is asserted and afterwards until the first command, `scl_o` = 1 and `sda_oe_o` = 0. `sda_o` is 0 at all times. `busy_o`, `done_o` and `rx_byte_o` are 0, and `ack_o` is 1.
- R2: A command is accepted on a clock edge where `cmd_valid_i` = 1, `busy_o` = 0 and `cmd_op_i` is one of the following. START = 0, STOP = 1, WRITE = 2, READ = 3, RECOVER = 4. Opcodes 5 to 7, and any request made while busy, are ignored and leave the bus lines unchanged.
- R3: A delay unit lasts `div_i + 1` clock cycles, and the bus lines change only at unit boundaries. From the accepting edge to `done_o`, a command takes this many units: START 4, STOP 5, WRITE 38, READ 30, RECOVER 42.
- R4: START releases SDA, then releases SCL, then pulls SDA low while SCL is high. It ends with SCL high and SDA driven low.
- R5: STOP pulls SCL low, then SDA low, then releases SCL, then releases SDA while SCL is high. It ends with both lines released.
- R6: WRITE sends `cmd_data_i` MSB first over 8 clocks. On each clock, SCL goes low and SDA changes one unit later. SCL is low for 2 units and high for 2 units, and SDA holds steady while SCL is high.
- R7: On the ninth clock of a WRITE, SDA is released. `ack_o` takes the SDA level seen just before SCL falls at the end of that clock's 2-unit high phase (0 = ACK, 1 = NACK), and the engine does not abort.
- R8: READ releases SDA and shifts 8 bits into `rx_byte_o`, MSB first. Each bit is sampled one unit after SCL rises.
- R9: On the ninth clock of a READ, the master drives `cmd_ack_i` onto SDA (0 = ACK, held low; 1 = NACK, released). SCL is high for 2 units and then low for 1 unit.
- R10: RECOVER releases both lines, then gives nine SCL clocks with SDA released, each phase lasting 2 units. It then performs a STOP and ends with both lines released.
- R11: `done_o` is high for exactly one cycle per command. `busy_o` drops in that same cycle, so a new command can be accepted there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 3 | Opcode: 0 START, 1 STOP, 2 WRITE, 3 READ, 4 RECOVER |
| cmd_data_i | input | DATA_W | Byte to send for WRITE |
| cmd_ack_i | input | 1 | Acknowledge level to drive after a READ |
| div_i | input | DIV_W | Delay unit reload value (unit = div_i+1 cycles) |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_o | output | 1 | SCL level (0 = pull low, 1 = release) |
| sda_oe_o | output | 1 | SDA pull-down enable |
| sda_o | output | 1 | SDA output value, always 0 |
| rx_byte_o | output | DATA_W | Byte received by the last READ |
| ack_o | output | 1 | Acknowledge level sampled by the last WRITE |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with DIV_W = 4, DATA_W = 8 and REC_CLKS = 9. Every reload value from 0 to 15 is therefore in reach. A reload of 0 makes each unit one cycle long, so ticks arrive back to back and a bus sample lands one cycle after the edge that set it up. A reload of 15 stretches the recovery command to 672 cycles. A bus model on the bench side answers reads and acknowledges writes, so phase lengths, bit order and the sampled levels are all measured on the lines themselves.

// File: rtl/i2c_sym_pkg.sv
package i2c_sym_pkg;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_STOP    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_READ    = 3'd3,
    OP_RECOVER = 3'd4
  } op_e;

  // One unit-boundary action
  typedef struct packed {
    logic scl_set;
    logic scl_val;
    logic sda_set;
    logic sda_val;
    logic sda_tx;   // drive next data bit
    logic sample;   // capture sda_i
    logic last;     // command ends here
  } act_t;

endpackage

// File: rtl/i2c_sym_tick.sv
module i2c_sym_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] reload_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= reload_i;
    else if (run_i)   cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
  end

  assign tick_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/i2c_sym_steps.sv
module i2c_sym_steps
  import i2c_sym_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int REC_CLKS = 9,
  parameter int STEP_W   = 6
) (
  input  op_e               op_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              ack_lvl_i,
  output act_t              act_o
);

  localparam logic [STEP_W-1:0] WA0 = STEP_W'(4*DATA_W);
  localparam logic [STEP_W-1:0] WA1 = STEP_W'(4*DATA_W+1);
  localparam logic [STEP_W-1:0] WA2 = STEP_W'(4*DATA_W+2);
  localparam logic [STEP_W-1:0] WA4 = STEP_W'(4*DATA_W+4);
  localparam logic [STEP_W-1:0] RA0 = STEP_W'(3*DATA_W);
  localparam logic [STEP_W-1:0] RA1 = STEP_W'(3*DATA_W+1);
  localparam logic [STEP_W-1:0] RA2 = STEP_W'(3*DATA_W+2);
  localparam logic [STEP_W-1:0] RA4 = STEP_W'(3*DATA_W+4);
  localparam logic [STEP_W-1:0] RA5 = STEP_W'(3*DATA_W+5);
  localparam logic [STEP_W-1:0] RC0 = STEP_W'(1+4*REC_CLKS);
  localparam logic [STEP_W-1:0] RC1 = STEP_W'(2+4*REC_CLKS);
  localparam logic [STEP_W-1:0] RC2 = STEP_W'(3+4*REC_CLKS);
  localparam logic [STEP_W-1:0] RC3 = STEP_W'(4+4*REC_CLKS);
  localparam logic [STEP_W-1:0] THREE = STEP_W'(3);

  logic [STEP_W-1:0] rd_ph;
  logic [1:0]        rc_ph;

  assign rd_ph = step_i % THREE;
  assign rc_ph = step_i[1:0] - 2'd1;

  always_comb begin
    act_o = '0;
    case (op_i)
      OP_START: begin
        if (step_i == 0)      begin act_o.sda_set = 1'b1; act_o.sda_val = 1'b1; end
        else if (step_i == 1) begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b1; end
        else if (step_i == 2) begin act_o.sda_set = 1'b1; act_o.sda_val = 1'b0; end
        else                        act_o.last = 1'b1;
      end
      OP_STOP: begin
        if (step_i == 0)      begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b0; end
        else if (step_i == 1) begin act_o.sda_set = 1'b1; act_o.sda_val = 1'b0; end
        else if (step_i == 2) begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b1; end
        else if (step_i == 3) begin act_o.sda_set = 1'b1; act_o.sda_val = 1'b1; end
        else                        act_o.last = 1'b1;
      end
      OP_WRITE: begin
        if (step_i < WA0) begin
          case (step_i[1:0])
            2'd0:    begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b0; end
            2'd1:          act_o.sda_tx  = 1'b1;
            2'd2:    begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b1; end
            default: ;
          endcase
        end
        else if (step_i == WA0) begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b0; end
        else if (step_i == WA1) begin act_o.sda_set = 1'b1; act_o.sda_val = 1'b1; end
        else if (step_i == WA2) begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b1; end
        else if (step_i == WA4) begin
          act_o.scl_set = 1'b1; act_o.scl_val = 1'b0; act_o.sample = 1'b1;
        end
        else if (step_i > WA4) act_o.last = 1'b1;
      end
      OP_READ: begin
        if (step_i < RA0) begin
          if (rd_ph == 0) begin
            act_o.scl_set = 1'b1; act_o.scl_val = 1'b0;
            act_o.sda_set = 1'b1; act_o.sda_val = 1'b1;
          end
          else if (rd_ph == 1) begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b1; end
          else act_o.sample = 1'b1;
        end
        else if (step_i == RA0) begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b0; end
        else if (step_i == RA1) begin act_o.sda_set = 1'b1; act_o.sda_val = ack_lvl_i; end
        else if (step_i == RA2) begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b1; end
        else if (step_i == RA4) begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b0; end
        else if (step_i >= RA5) act_o.last = 1'b1;
      end
      OP_RECOVER: begin
        if (step_i == 0) begin
          act_o.scl_set = 1'b1; act_o.scl_val = 1'b1;
          act_o.sda_set = 1'b1; act_o.sda_val = 1'b1;
        end
        else if (step_i < RC0) begin
          if (rc_ph == 2'd0)      begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b0; end
          else if (rc_ph == 2'd2) begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b1; end
        end
        else if (step_i == RC0) begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b0; end
        else if (step_i == RC1) begin act_o.sda_set = 1'b1; act_o.sda_val = 1'b0; end
        else if (step_i == RC2) begin act_o.scl_set = 1'b1; act_o.scl_val = 1'b1; end
        else if (step_i == RC3) begin act_o.sda_set = 1'b1; act_o.sda_val = 1'b1; end
        else                          act_o.last = 1'b1;
      end
      default: act_o.last = 1'b1;
    endcase
  end

endmodule

// File: rtl/i2c_sym_shreg.sv
module i2c_sym_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              shl_i,
  input  logic              shin_i,
  input  logic              sda_i,
  output logic [DATA_W-1:0] q_o,
  output logic              msb_o
);

  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= load_val_i;
    else if (shl_i)   sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    else if (shin_i)  sh_q <= {sh_q[DATA_W-2:0], sda_i};
  end

  assign q_o   = sh_q;
  assign msb_o = sh_q[DATA_W-1];

endmodule

// File: rtl/i2c_sym_engine.sv
module i2c_sym_engine
  import i2c_sym_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DATA_W   = 8,
  parameter int REC_CLKS = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cmd_ack_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_oe_o,
  output logic              sda_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              ack_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int WR_LAST  = 4*DATA_W + 5;
  localparam int RC_LAST  = 4*REC_CLKS + 5;
  localparam int MAX_STEP = (WR_LAST > RC_LAST) ? WR_LAST : RC_LAST;
  localparam int STEP_W   = $clog2(MAX_STEP + 1);

  logic              busy_q, done_q, scl_q, sda_q, ack_q, ack_lvl_q;
  op_e               op_q;
  logic [STEP_W-1:0] step_q;
  logic              tick, accept, op_ok, tx_bit;
  act_t              act;

  assign op_ok  = (cmd_op_i <= 3'd4);
  assign accept = cmd_valid_i && !busy_q && op_ok;

  i2c_sym_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy_q),
    .load_i   (accept),
    .reload_i (div_i),
    .tick_o   (tick)
  );

  i2c_sym_steps #(.DATA_W(DATA_W), .REC_CLKS(REC_CLKS), .STEP_W(STEP_W)) u_steps (
    .op_i      (op_q),
    .step_i    (step_q),
    .ack_lvl_i (ack_lvl_q),
    .act_o     (act)
  );

  i2c_sym_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i ((cmd_op_i == OP_WRITE) ? cmd_data_i : '0),
    .shl_i      (tick && act.sda_tx),
    .shin_i     (tick && act.sample && (op_q == OP_READ)),
    .sda_i      (sda_i),
    .q_o        (rx_byte_o),
    .msb_o      (tx_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      op_q      <= OP_START;
      step_q    <= '0;
      ack_lvl_q <= 1'b1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      ack_q     <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q    <= 1'b1;
        op_q      <= op_e'(cmd_op_i);
        step_q    <= '0;
        ack_lvl_q <= cmd_ack_i;
      end else if (tick) begin
        if (act.scl_set) scl_q <= act.scl_val;
        if (act.sda_set) sda_q <= act.sda_val;
        if (act.sda_tx)  sda_q <= tx_bit;
        if (act.sample && (op_q == OP_WRITE)) ack_q <= sda_i;
        if (act.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  // Open drain: a 1 is a release
  assign scl_o    = scl_q;
  assign sda_oe_o = !sda_q;
  assign sda_o    = 1'b0;
  assign ack_o    = ack_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

endmodule

// File: rtl/i2c_sym_engine_chk.sv
module i2c_sym_engine_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [2:0]       op_i,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_op_i,
  input logic [DIV_W-1:0] div_i,
  input logic             scl_i,
  input logic             sda_oe_i,
  input logic             busy_i,
  input logic             done_i
);

  a_r3_lines_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(scl_i) && $stable(sda_oe_i)));

  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && div_i != '0) |=> !tick_i);

  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  a_r2_accept_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> ($past(cmd_valid_i) && $past(cmd_op_i) <= 3'd4));

  a_r6_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && (op_i == 3'd2 || op_i == 3'd3) && scl_i && $past(scl_i))
      |-> $stable(sda_oe_i));

endmodule

bind i2c_sym_engine i2c_sym_engine_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick),
  .op_i        (op_q),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .div_i       (div_i),
  .scl_i       (scl_o),
  .sda_oe_i    (sda_oe_o),
  .busy_i      (busy_o),
  .done_i      (done_o)
);

// File: tb/sim_i2c_sym_engine.sv
module sim_i2c_sym_engine;
  localparam int DIV_W  = 4;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             cmd_valid = 1'b0;
  logic [2:0]       cmd_op = 3'd0;
  logic [7:0]       cmd_data = 8'd0;
  logic             cmd_ack = 1'b0;
  logic [DIV_W-1:0] div_r = '0;
  logic             scl, sda_oe, sda_out, ack, busy, done;
  logic [7:0]       rx;
  logic             slave_pull;
  wire              sda_line = !sda_oe && !slave_pull;

  i2c_sym_engine #(.DIV_W(DIV_W), .DATA_W(DATA_W), .REC_CLKS(9)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .cmd_ack_i(cmd_ack), .div_i(div_r), .sda_i(sda_line),
    .scl_o(scl), .sda_oe_o(sda_oe), .sda_o(sda_out), .rx_byte_o(rx),
    .ack_o(ack), .busy_o(busy), .done_o(done)
  );

  int nchk = 0, nbad = 0;

  // bus monitor, updated on falling clock edges
  int rises = 0, falls = 0, starts = 0, stops = 0, drv_rises = 0, dones = 0;
  int hold = 0, hi_len = 0, lo_len = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  logic [15:0] cap = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) dones++;
      if (scl && prev_scl && sda_line !== prev_sda) begin
        if (!sda_line) starts++; else stops++;
      end
      if (scl !== prev_scl) begin
        if (scl) begin rises++; if (sda_oe) drv_rises++; lo_len = hold; end
        else begin falls++; cap = {cap[14:0], prev_sda}; hi_len = hold; end
        hold = 1;
      end else hold++;
    end
    prev_scl = scl;
    prev_sda = sda_line;
  end

  // slave model
  int smode = 0;  // 0 idle, 1 acks a write, 2 answers a read
  logic sack = 1'b0;
  logic [7:0] sbyte = '0;
  int rbase = 0, sr, si;
  always_comb begin
    sr = rises - rbase;
    si = scl ? sr - 1 : sr;
    slave_pull = 1'b0;
    if (smode == 2 && si >= 0 && si < 8) slave_pull = !sbyte[7-si];
    else if (smode == 1 && sack) slave_pull = (sr == 8 && !scl) || (sr == 9 && scl);
  end

  int s_falls, s_starts, s_stops, s_drv, s_dones;

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  function automatic int units(input int op);
    case (op)
      0: return 4;
      1: return 5;
      2: return 38;
      3: return 30;
      default: return 42;
    endcase
  endfunction

  // issue op; hold_n>0 keeps the request up (as alt_op) while busy
  task automatic run(input int op, input int dv, input int hold_n, input int alt_op);
    int lat = 0;
    int j = 0;
    @(negedge clk);
    div_r = DIV_W'(dv);
    cmd_op = 3'(op);
    cmd_valid = 1'b1;
    @(posedge clk);
    s_falls = falls; s_starts = starts; s_stops = stops; s_drv = drv_rises; s_dones = dones;
    rbase = rises;
    forever begin
      @(negedge clk);
      if (j == 0) cmd_op = 3'(alt_op);
      if (j >= hold_n) cmd_valid = 1'b0;
      j++;
      if (done) break;
      lat++;
      if (lat > 4000) begin chk(0, "R3 hang", lat, 0); break; end
    end
    chk(lat == units(op) * (dv + 1), "R3 latency", lat, units(op) * (dv + 1));
    chk(!busy, "R11 busy low with done", busy, 0);
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
    @(posedge clk);
  endtask

  task automatic do_start(input int dv);
    run(0, dv, 0, 0);
    chk(starts - s_starts == 1, "R4 start event", starts - s_starts, 1);
    chk(scl && sda_oe, "R4 end state", {scl, sda_oe}, 3);
  endtask

  task automatic do_stop(input int dv);
    run(1, dv, 0, 1);
    chk(stops - s_stops == 1, "R5 stop event", stops - s_stops, 1);
    chk(scl && !sda_oe, "R5 end state", {scl, sda_oe}, 2);
  endtask

  task automatic do_write(input logic [7:0] d, input logic a, input int dv);
    cmd_data = d; sack = a; smode = 1;
    run(2, dv, 0, 2);
    smode = 0;
    chk(cap[8:1] == d, "R6 bits msb first", cap[8:1], d);
    chk(hi_len == 2 * (dv + 1), "R6 high phase", hi_len, 2 * (dv + 1));
    chk(lo_len == 2 * (dv + 1), "R6 low phase", lo_len, 2 * (dv + 1));
    chk(ack == !a, "R7 ack level", ack, !a);
    chk(cap[0] == !a, "R7 released ack clock", cap[0], !a);
  endtask

  task automatic do_read(input logic [7:0] b, input logic a, input int dv);
    sbyte = b; cmd_ack = a; smode = 2;
    run(3, dv, 0, 3);
    smode = 0;
    chk(rx == b, "R8 received byte", rx, b);
    chk(cap[0] == a, "R9 master ack level", cap[0], a);
    chk(hi_len == 2 * (dv + 1), "R9 ack high phase", hi_len, 2 * (dv + 1));
  endtask

  task automatic do_recover(input int dv);
    run(4, dv, 0, 4);
    chk(falls - s_falls == 10, "R10 clock count", falls - s_falls, 10);
    chk(drv_rises - s_drv == 1, "R10 sda released on nine clocks", drv_rises - s_drv, 1);
    chk(stops - s_stops >= 1, "R10 ends with stop", stops - s_stops, 1);
    chk(scl && !sda_oe, "R10 end released", {scl, sda_oe}, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(scl && !sda_oe && !sda_out, "R1 lines in reset", {scl, sda_oe, sda_out}, 4);
    chk(!busy && !done && rx == 0 && ack, "R1 status in reset", {busy, done, ack}, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl && !sda_oe && !busy, "R1 idle after reset", {scl, sda_oe, busy}, 4);

    do_start(0);
    do_write(8'hA5, 1'b1, 0);
    do_write(8'h5A, 1'b0, 15);
    do_start(3);
    do_read(8'h3C, 1'b1, 15);
    do_read(8'hC3, 1'b0, 0);
    do_recover(1);
    do_stop(2);

    // R2: requests while busy are ignored
    run(0, 3, 6, 1);
    repeat (20) @(negedge clk);
    chk(!busy, "R2 busy request ignored", busy, 0);
    chk(stops == s_stops, "R2 no stop issued", stops - s_stops, 0);
    chk(dones - s_dones == 1, "R2 single done", dones - s_dones, 1);
    chk(scl && sda_oe, "R2 start state kept", {scl, sda_oe}, 3);

    // R2: illegal opcode
    s_dones = dones;
    @(negedge clk); cmd_op = 3'd6; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    chk(!busy, "R2 illegal opcode", busy, 0);
    repeat (10) @(negedge clk);
    chk(dones == s_dones && scl && sda_oe, "R2 illegal opcode lines", {scl, sda_oe}, 3);

    do_stop(0);
    do_recover(15);

    for (int it = 0; it < 30; it++) begin
      int kind = $urandom_range(0, 4);
      int dv = $urandom_range(0, 15);
      logic [7:0] d = 8'($urandom);
      logic a = 1'($urandom);
      case (kind)
        0, 1: do_write(d, a, dv);
        2:    do_read(d, a, dv);
        3:    do_start(dv);
        default: do_stop(dv);
      endcase
    end

    do_read(8'h00, 1'b0, 2);
    do_recover(0);
    do_write(8'hFF, 1'b0, 1);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule